// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and a 64K x 1 asynchronous static RAM that has separate data-in and data-out pins. The host raises a request with a read/write select, a 16-bit address and, for writes, one data bit. The block turns each request into chip-enable, write-enable, address and data-in strobes on the memory pins. For a read, it returns the bit on the memory's output pin as a one-cycle valid pulse.

All memory timing is set through parameters in picoseconds. These are the clock period, the address access time, the read cycle time, the write pulse width and the write cycle time. The block rounds each of them up to whole clock cycles when it is elaborated.

Writes are ended by write enable. Write enable rises one cycle before chip enable does, and address and data-in stay fixed for the whole strobe. Chip enable always returns high for at least one cycle between two accesses. While an access is in progress the block reports busy, and it ignores any new request.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `sram_ce_n_o` and `sram_we_n_o` are 1 and `busy_o` and `rvalid_o` are 0.
- R2: A read request is accepted at a clock edge while the block is idle. In the next cycle `sram_ce_n_o`=0, `sram_we_n_o`=1 and `sram_addr_o` equals the requested address. Exactly one `rvalid_o` pulse follows, with `rdata_o` equal to the bit last written to that address (0 if that address was never written). A write request produces no `rvalid_o` pulse.
- R3: Read data is captured at the edge that ends the chip-enable-low window. That window lasts RD_LEN = max(ceil(tAA/T), ceil(tRC/T)) cycles, so data is never sampled earlier than ceil(tAA/T) cycles after the address and chip enable are applied. `rvalid_o` is high in cycle RD_LEN+1 counted from acceptance, which is cycle 4 with the default parameters.
- R4: A write drives `sram_we_n_o` low for exactly WP_CYC = ceil(tWP/T) cycles, starting in the first cycle after acceptance. `sram_din_o` carries the write bit from that first cycle and does not change while `sram_we_n_o` is low. The bit is stored when `sram_we_n_o` rises.
- R5: `sram_we_n_o` is never 0 while `sram_ce_n_o` is 1. In the cycle in which `sram_we_n_o` rises, `sram_ce_n_o` is still 0.
- R6: `sram_addr_o` does not change while `sram_ce_n_o` stays 0.
- R7: `busy_o` rises in the cycle after acceptance and stays high for LEN+1 cycles, where LEN is RD_LEN for a read or WR_LEN = max(WP_CYC+1, ceil(tWC/T)) for a write. Requests presented while `busy_o` is high are ignored, and they leave the memory contents unchanged.
- R8: After `sram_ce_n_o` rises, it stays high for at least one full cycle before the next access begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Access request, sampled while idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Host address |
| wdata_i | input | 1 | Write data bit |
| busy_o | output | 1 | Access in progress; requests are ignored |
| rvalid_o | output | 1 | One-cycle pulse: rdata_o holds read data |
| rdata_o | output | 1 | Captured read bit |
| sram_addr_o | output | ADDR_W | Memory address pins |
| sram_ce_n_o | output | 1 | Memory chip enable, active low |
| sram_we_n_o | output | 1 | Memory write enable, active low |
| sram_din_o | output | 1 | Memory data-in pin |
| sram_dout_i | input | 1 | Memory data-out pin |

## Verification
A read completes in the same cycle that `busy_o` is still high during the chip-enable gap. This is when a host that keeps its request asserted would try to start the next access, so the two can fall in the same cycle. The bench provokes this by holding a write request to a second address, with the complement of its stored bit, for as long as `busy_o` is high after a read or a write. It then judges the outcome from the `rvalid_o` timing of the first access and from a later read of the second address, which must return the original bit. The memory model presents inverted data until the access time has elapsed, so a capture made too early shows up as a wrong read bit.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_GAP    = 2'd2
  } acc_state_e;

  // Round a time in picoseconds up to whole clock cycles.
  function automatic int unsigned cyc_of(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = count_q;
    if (clr_i) begin
      count_d = '0;
    end else if (en_i) begin
      count_d = count_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/sram_access_fsm.sv
module sram_access_fsm
  import sram_strobe_pkg::*;
#(
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned RD_LEN = 3,
  parameter int unsigned WR_LEN = 3,
  parameter int unsigned WP_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             accept_o,
  output logic             timer_clr_o,
  output logic             timer_en_o,
  output logic             sample_o,
  output logic             ce_n_o,
  output logic             we_n_o,
  output logic             busy_o
);

  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_LEN - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_LEN - 1);
  localparam logic [CNT_W-1:0] WE_LAST = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] WE_LEN  = CNT_W'(WP_CYC);

  acc_state_e state_q, state_d;
  logic       op_wr_q, op_wr_d;
  logic       ce_n_q, ce_n_d;
  logic       we_n_q, we_n_d;
  logic       busy_q, busy_d;
  logic       accept;
  logic       in_access;
  logic       last_cyc;

  assign accept    = (state_q == ST_IDLE) && req_i;
  assign in_access = (state_q == ST_ACCESS);
  assign last_cyc  = op_wr_q ? (count_i == WR_LAST) : (count_i == RD_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept)   state_d = ST_ACCESS;
      ST_ACCESS: if (last_cyc) state_d = ST_GAP;
      ST_GAP:                  state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    op_wr_d = op_wr_q;
    ce_n_d  = ce_n_q;
    we_n_d  = we_n_q;
    if (accept) begin
      op_wr_d = wr_i;
      ce_n_d  = 1'b0;
      we_n_d  = ~wr_i;
    end else if (in_access) begin
      if (op_wr_q && (count_i == WE_LAST)) begin
        we_n_d = 1'b1;
      end
      if (last_cyc) begin
        ce_n_d = 1'b1;
      end
    end
    busy_d = (state_d != ST_IDLE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_wr_q <= 1'b0;
      ce_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      op_wr_q <= op_wr_d;
      ce_n_q  <= ce_n_d;
      we_n_q  <= we_n_d;
      busy_q  <= busy_d;
    end
  end

  assign accept_o    = accept;
  assign timer_clr_o = accept;
  assign timer_en_o  = in_access;
  assign sample_o    = in_access && last_cyc && !op_wr_q;
  assign ce_n_o      = ce_n_q;
  assign we_n_o      = we_n_q;
  assign busy_o      = busy_q;

  // Checker counter: cycles write enable has been low in the current strobe.
  logic [CNT_W-1:0] we_low_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_low_cnt_q <= '0;
    end else if (we_n_q) begin
      we_low_cnt_q <= '0;
    end else begin
      we_low_cnt_q <= we_low_cnt_q + 1'b1;
    end
  end

  AST_WE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_q) |-> (we_low_cnt_q == WE_LEN)); // R4
  AST_WE_INSIDE_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_n_q |-> we_n_q); // R5
  AST_CE_HELD_AT_WE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_q) |-> !ce_n_q); // R5
  AST_CE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce_n_q) |=> ce_n_q); // R8
  AST_BUSY_COVERS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_n_q |-> busy_q); // R7

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              din_o
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              din_q, din_d;

  always_comb begin
    addr_d = addr_q;
    din_d  = din_q;
    if (load_i) begin
      addr_d = addr_i;
      din_d  = din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      din_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      din_q  <= din_d;
    end
  end

  assign addr_o = addr_q;
  assign din_o  = din_q;

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic dout_i,
  output logic rdata_o,
  output logic rvalid_o
);

  logic rdata_q, rdata_d;
  logic rvalid_q, rvalid_d;

  always_comb begin
    rdata_d  = rdata_q;
    rvalid_d = sample_i;
    if (sample_i) begin
      rdata_d = dout_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  AST_RVALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_q |=> !rvalid_q); // R2

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned CLK_PS   = 4000,
  parameter int unsigned T_AA_PS  = 10000,
  parameter int unsigned T_RC_PS  = 10000,
  parameter int unsigned T_WP_PS  = 8000,
  parameter int unsigned T_WC_PS  = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wdata_i,
  output logic              busy_o,
  output logic              rvalid_o,
  output logic              rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_n_o,
  output logic              sram_we_n_o,
  output logic              sram_din_o,
  input  logic              sram_dout_i
);

  localparam int unsigned AA_CYC = cyc_of(T_AA_PS, CLK_PS);
  localparam int unsigned RC_CYC = cyc_of(T_RC_PS, CLK_PS);
  localparam int unsigned WP_CYC = cyc_of(T_WP_PS, CLK_PS);
  localparam int unsigned WC_CYC = cyc_of(T_WC_PS, CLK_PS);
  localparam int unsigned RD_LEN = max2(AA_CYC, RC_CYC);
  localparam int unsigned WR_LEN = max2(WP_CYC + 1, WC_CYC);
  localparam int unsigned CNT_W  = $clog2(max2(RD_LEN, WR_LEN) + 1);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  logic             accept;
  logic             timer_clr;
  logic             timer_en;
  logic             sample;
  logic [CNT_W-1:0] count;

  sram_cycle_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .clr_i   (timer_clr),
    .en_i    (timer_en),
    .count_o (count)
  );

  sram_access_fsm #(
    .CNT_W  (CNT_W),
    .RD_LEN (RD_LEN),
    .WR_LEN (WR_LEN),
    .WP_CYC (WP_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .req_i       (req_i),
    .wr_i        (wr_i),
    .count_i     (count),
    .accept_o    (accept),
    .timer_clr_o (timer_clr),
    .timer_en_o  (timer_en),
    .sample_o    (sample),
    .ce_n_o      (sram_ce_n_o),
    .we_n_o      (sram_we_n_o),
    .busy_o      (busy_o)
  );

  sram_pin_regs #(
    .ADDR_W (ADDR_W)
  ) u_pins (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .load_i (accept),
    .addr_i (addr_i),
    .din_i  (wdata_i),
    .addr_o (sram_addr_o),
    .din_o  (sram_din_o)
  );

  sram_rd_capture u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .sample_i (sample),
    .dout_i   (sram_dout_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!sram_ce_n_o && !$past(sram_ce_n_o)) |-> $stable(sram_addr_o)); // R6
  AST_DIN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!sram_we_n_o && !$past(sram_we_n_o)) |-> $stable(sram_din_o)); // R4
  AST_READ_AFTER_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(rvalid_o) |-> ($past(!sram_ce_n_o) && $past(sram_we_n_o))); // R3

endmodule

// File: tb/sram_strobe_ctrl_tb_top.sv
module sram_strobe_ctrl_tb_top;

  localparam int CLK_PS = 4000;
  localparam int AA     = (10000 + CLK_PS - 1) / CLK_PS;
  localparam int RC     = (10000 + CLK_PS - 1) / CLK_PS;
  localparam int WP     = (8000 + CLK_PS - 1) / CLK_PS;
  localparam int WC     = (10000 + CLK_PS - 1) / CLK_PS;
  localparam int RD_LEN = (AA > RC) ? AA : RC;
  localparam int WR_LEN = ((WP + 1) > WC) ? (WP + 1) : WC;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, wr, wdata;
  logic [15:0] addr;
  logic        busy, rvalid, rdata;
  logic [15:0] sram_addr;
  logic        ce_n, we_n, din;
  logic        dout_r;

  int n_chk = 0;
  int n_bad = 0;

  // 250 MHz: 4 time units per period.
  always #2 clk = ~clk;

  sram_strobe_ctrl dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_i       (req),
    .wr_i        (wr),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .busy_o      (busy),
    .rvalid_o    (rvalid),
    .rdata_o     (rdata),
    .sram_addr_o (sram_addr),
    .sram_ce_n_o (ce_n),
    .sram_we_n_o (we_n),
    .sram_din_o  (din),
    .sram_dout_i (dout_r)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Memory model and bench shadow (sparse).
  logic model_mem [int];
  logic shadow    [int];

  function automatic logic mread(input logic [15:0] a);
    return model_mem.exists(int'(a)) ? model_mem[int'(a)] : 1'b0;
  endfunction

  function automatic logic exp_bit(input logic [15:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 1'b0;
  endfunction

  int age = 0;
  always @(posedge clk) age <= (!ce_n && we_n) ? age + 1 : 0;

  // Output is wrong (inverted) until the access time has elapsed at the next edge.
  always @(negedge clk) begin
    if (!ce_n && we_n) dout_r <= (age + 1 >= AA) ? mread(sram_addr) : ~mread(sram_addr);
    else               dout_r <= 1'b0;
  end

  bit   mon_on = 1'b0;
  logic we_prev = 1'b1, ce_prev = 1'b1, ce_rose = 1'b0;
  int   we_low = 0;
  logic din_start = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (ce_n && !we_n) check(1'b0, "R5 we low with ce high", int'(we_n), 1);
      if (ce_rose && !ce_n) check(1'b0, "R8 ce gap", int'(ce_n), 1);
      if (we_prev && !we_n) begin
        we_low = 0;
        din_start = din;
      end
      if (!we_n) begin
        we_low++;
        if (din !== din_start) check(1'b0, "R4 din moved", int'(din), int'(din_start));
      end
      if (!we_prev && we_n) begin
        check(we_low == WP, "R4 we width", we_low, WP);
        check(!ce_n, "R5 ce low at we rise", int'(ce_n), 0);
        model_mem[int'(sram_addr)] = din_start;
      end
      ce_rose = ce_n && !ce_prev;
    end
    we_prev = we_n;
    ce_prev = ce_n;
  end

  task automatic run_op(input bit w, input logic [15:0] a, input bit d,
                        input bit flood, input logic [15:0] fa);
    int   kv = 0;
    int   ki = 0;
    logic got = 1'b0;
    int   g = 0;
    while (busy && g < 50) begin
      @(negedge clk);
      g++;
    end
    req = 1'b1; wr = w; addr = a; wdata = d;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (flood && busy) begin
        req = 1'b1; wr = 1'b1; addr = fa; wdata = ~exp_bit(fa);
      end else begin
        req = 1'b0;
      end
      if (k == 1) begin
        check(ce_n == 1'b0, "R2 ce low first cycle", int'(ce_n), 0);
        check(sram_addr == a, "R6 address presented", int'(sram_addr), int'(a));
        check(we_n == ~w, "R4 we level first cycle", int'(we_n), int'(~w));
        if (w) check(din == d, "R4 din first cycle", int'(din), int'(d));
        check(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
      end
      if (rvalid && kv == 0) begin
        kv = k;
        got = rdata;
      end
      if (!busy && ki == 0) ki = k;
    end
    if (!w) begin
      check(kv == RD_LEN + 1, "R3 rvalid cycle", kv, RD_LEN + 1);
      check(got == exp_bit(a), "R2 read data", int'(got), int'(exp_bit(a)));
      check(ki == RD_LEN + 2, "R7 busy length read", ki, RD_LEN + 2);
    end else begin
      check(kv == 0, "R2 no rvalid on write", kv, 0);
      check(ki == WR_LEN + 2, "R7 busy length write", ki, WR_LEN + 2);
      shadow[int'(a)] = d;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  logic [15:0] pool [8];

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req = 1'b0; wr = 1'b0; addr = '0; wdata = 1'b0;
    repeat (3) @(negedge clk);
    check(ce_n && we_n && !busy && !rvalid, "R1 reset idle",
          int'({ce_n, we_n, busy, rvalid}), 4'b1100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ce_n && we_n && !busy && !rvalid, "R1 idle after release",
          int'({ce_n, we_n, busy, rvalid}), 4'b1100);
    mon_on = 1'b1;

    // Directed corners: extreme addresses, unwritten read, write-then-read.
    run_op(1'b0, 16'h1234, 1'b0, 1'b0, 16'h0);
    run_op(1'b1, 16'hFFFF, 1'b1, 1'b0, 16'h0);
    run_op(1'b0, 16'hFFFF, 1'b0, 1'b0, 16'h0);
    run_op(1'b1, 16'h0000, 1'b1, 1'b0, 16'h0);
    run_op(1'b1, 16'h0000, 1'b0, 1'b0, 16'h0);
    run_op(1'b0, 16'h0000, 1'b0, 1'b0, 16'h0);
    // Held request while busy must be ignored (R7).
    run_op(1'b1, 16'h00A5, 1'b1, 1'b1, 16'h5A00);
    run_op(1'b0, 16'h00A5, 1'b0, 1'b1, 16'h5A00);
    run_op(1'b0, 16'h5A00, 1'b0, 1'b0, 16'h0);

    for (int i = 0; i < 8; i++) pool[i] = 16'($urandom);
    for (int n = 0; n < 120; n++) begin
      logic [15:0] a = pool[$urandom % 8];
      bit          w = 1'($urandom);
      bit          d = 1'($urandom);
      bit          f = (($urandom % 6) == 0);
      run_op(w, a, d, f, pool[$urandom % 8] ^ 16'h8000);
    end
    for (int i = 0; i < 8; i++) run_op(1'b0, pool[i], 1'b0, 1'b0, 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule